// File: doc/BRIEF.md
# Line-Locked Programmable Feedback Divider

This block is the digital divider in the feedback path of a line-locked clock synthesizer. It counts periods of the synthesized clock and emits a one-cycle regenerated line pulse once per line. A line is the programmed value plus eight clock periods long. That pulse is the feedback sent to the phase comparator. It can also drive a function output, which may instead carry a cleaned-up, one-cycle version of the incoming line sync.

The programmed value is a 12-bit quantity. Software assembles it from an 8-bit low register (bits 7:0) and the low nibble of a high register (bits 11:8). The value is double-buffered: the working modulus changes only when a PLL restart strobe arrives. On that strobe the divider restarts from zero. Values that would give a line shorter than 12 clocks are clamped to 12. A feedback-select input lets an external divider replace the internal one, with optional inversion of the external signal.

The divider is a two-state machine. COUNT advances the period counter. WRAP is the single cycle in which the line pulse is driven. The transitions are COUNT to WRAP when the counter reaches modulus minus two, WRAP to COUNT always (counter cleared), and any state to COUNT with the counter cleared on a restart strobe.

Top module: `line_fb_divider`

## Requirements
- R1: With working modulus M, the divider pulse repeats with a period of exactly M clocks, where M is the committed programmed value plus 8.
- R2: A committed value below 4 gives M = 12. Values from 4 to 4095 give M = value + 8, so the range is 12 to 4103.
- R3: A change on prog_val without a pll_restart strobe leaves the pulse period unchanged.
- R4: A pll_restart strobe commits prog_val and restarts the count. Counting the cycle that begins at the sampling edge as cycle 0, the first pulse is high in cycle M-1, and then every M cycles.
- R5: The divider pulse is high for exactly one clock cycle per line.
- R6: While rst_n is low, both outputs are low. After reset the working modulus is 12.
- R7: A rising edge on hsync_in gives a one-cycle pulse. The pulse is high in the cycle that begins at the second rising clock edge after the rising edge of hsync_in. A held level gives no further pulse.
- R8: With func_sel = 1, func_out carries the hsync pulse. With func_sel = 0, it carries the internal divider pulse.
- R9: With fbk_sel = 0, fb_out is the internal divider pulse. With fbk_sel = 1, it is ext_fb XOR ext_fb_inv.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Synthesized output clock |
| rst_n | input | 1 | Active-low reset |
| prog_val | input | 12 | Programmed value: bits 7:0 from the low register, bits 11:8 from the high register nibble |
| pll_restart | input | 1 | Commits prog_val and restarts the count |
| fbk_sel | input | 1 | 1 selects the external feedback input |
| ext_fb | input | 1 | External feedback divider output |
| ext_fb_inv | input | 1 | Inverts ext_fb when 1 |
| func_sel | input | 1 | 1 routes the hsync pulse to func_out |
| hsync_in | input | 1 | Asynchronous line sync input |
| fb_out | output | 1 | Feedback pulse to the phase comparator |
| func_out | output | 1 | Function output |

## Verification
A wrong working modulus or a counter that is off by one shows at the ports within one line as a wrong pulse spacing. The bench therefore measures whole periods rather than single samples. A restart that fails to clear the counter shows as an early first pulse after the strobe. A broken double buffer shows as a changed period with no strobe. A stuck state machine shows as a pulse wider than one cycle, or no pulse at all. An error in the sync chain shows as a pulse one cycle early or late, or as a repeated pulse on a held level, within three clocks of the edge.

// File: rtl/lfd_pkg.sv
package lfd_pkg;

    localparam int VAL_W   = 12;
    localparam int MOD_W   = VAL_W + 1;
    localparam int OFFSET  = 8;
    localparam int MOD_MIN = 12;

    typedef enum logic [0:0] {
        ST_COUNT = 1'b0,
        ST_WRAP  = 1'b1
    } div_state_t;

endpackage

// File: rtl/lfd_modulus.sv
module lfd_modulus
    import lfd_pkg::*;
#(
    parameter int VW     = VAL_W,
    parameter int OFS    = OFFSET,
    parameter int MINMOD = MOD_MIN
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [VW-1:0] prog_val,
    output logic [VW:0]   mod_q
);

    localparam int MW = VW + 1;
    localparam logic [MW-1:0] MIN_V = MW'(MINMOD);
    localparam logic [MW-1:0] MAX_V = MW'((1 << VW) - 1 + OFS);

    logic [MW-1:0] sum;
    logic [MW-1:0] clamped;

    always_comb begin
        sum = {1'b0, prog_val} + MW'(OFS);
        clamped = (sum < MIN_V) ? MIN_V : sum;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mod_q <= MIN_V;
        end else if (load) begin
            mod_q <= clamped;
        end
    end

    // R2
    mod_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mod_q >= MIN_V) && (mod_q <= MAX_V));

    // R3
    mod_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mod_q));

endmodule

// File: rtl/lfd_div_fsm.sv
module lfd_div_fsm
    import lfd_pkg::*;
#(
    parameter int MW = MOD_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [MW-1:0] mod_val,
    output logic          div_pulse
);

    div_state_t    state_q, state_d;
    logic [MW-1:0] cnt_q, cnt_d;
    logic [MW-1:0] wrap_at;

    assign wrap_at = mod_val - MW'(2);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_COUNT;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        if (load) begin
            state_d = ST_COUNT;
            cnt_d   = '0;
        end else begin
            unique case (state_q)
                ST_COUNT: begin
                    if (cnt_q >= wrap_at) begin
                        state_d = ST_WRAP;
                        cnt_d   = cnt_q + MW'(1);
                    end else begin
                        cnt_d   = cnt_q + MW'(1);
                    end
                end
                ST_WRAP: begin
                    state_d = ST_COUNT;
                    cnt_d   = '0;
                end
                default: begin
                    state_d = ST_COUNT;
                    cnt_d   = '0;
                end
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            ST_WRAP:  div_pulse = 1'b1;
            default:  div_pulse = 1'b0;
        endcase
    end

    // R1
    cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < mod_val);

    // R5
    pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    // R4
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> !div_pulse);

endmodule

// File: rtl/lfd_edge_sync.sv
module lfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);

    logic [STAGES-1:0] chain_q;
    logic              prev_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[0] <= 1'b0;
                    else        chain_q[0] <= async_in;
                end
            end else begin : g_rest
                always_ff @(posedge clk or negedge rst_n) begin
                    if (!rst_n) chain_q[i] <= 1'b0;
                    else        chain_q[i] <= chain_q[i-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain_q[STAGES-1];
    end

    assign rise_pulse = chain_q[STAGES-1] & ~prev_q;

    // R7
    sync_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise_pulse |=> !rise_pulse);

endmodule

// File: rtl/line_fb_divider.sv
module line_fb_divider
    import lfd_pkg::*;
#(
    parameter int VW          = VAL_W,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [VW-1:0] prog_val,
    input  logic          pll_restart,
    input  logic          fbk_sel,
    input  logic          ext_fb,
    input  logic          ext_fb_inv,
    input  logic          func_sel,
    input  logic          hsync_in,
    output logic          fb_out,
    output logic          func_out
);

    localparam int MW = VW + 1;

    logic [MW-1:0] mod_w;
    logic          div_pulse;
    logic          hs_pulse;

    lfd_modulus #(.VW(VW), .OFS(OFFSET), .MINMOD(MOD_MIN)) u_mod (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (pll_restart),
        .prog_val (prog_val),
        .mod_q    (mod_w)
    );

    lfd_div_fsm #(.MW(MW)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (pll_restart),
        .mod_val   (mod_w),
        .div_pulse (div_pulse)
    );

    lfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .async_in   (hsync_in),
        .rise_pulse (hs_pulse)
    );

    assign fb_out   = fbk_sel  ? (ext_fb ^ ext_fb_inv) : div_pulse;
    assign func_out = func_sel ? hs_pulse : div_pulse;

    // R6
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |-> !div_pulse && !hs_pulse);

endmodule

// File: tb/tb_line_fb_divider.sv
module tb_line_fb_divider;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] prog_val = '0;
    logic        pll_restart = 1'b0;
    logic        fbk_sel = 1'b0;
    logic        ext_fb = 1'b0;
    logic        ext_fb_inv = 1'b0;
    logic        func_sel = 1'b0;
    logic        hsync_in = 1'b0;
    logic        fb_out;
    logic        func_out;

    int checks = 0;
    int failures = 0;
    int cyc = 0;

    always #10 clk = ~clk;

    line_fb_divider dut (
        .clk(clk), .rst_n(rst_n), .prog_val(prog_val), .pll_restart(pll_restart),
        .fbk_sel(fbk_sel), .ext_fb(ext_fb), .ext_fb_inv(ext_fb_inv),
        .func_sel(func_sel), .hsync_in(hsync_in), .fb_out(fb_out), .func_out(func_out)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            failures++;
            $display("FAIL watchdog: actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // counts cycles from the current sample until fb_out is high
    task automatic to_pulse(output int n);
        n = 0;
        while (!fb_out && n < 5000) begin
            @(negedge clk);
            n++;
        end
    endtask

    // at a pulse: measure the distance to the next pulse; also check width
    task automatic period(input string req, input int exp);
        int n;
        @(negedge clk);
        check("R5 width", fb_out, 0);
        n = 1;
        while (!fb_out && n < 5000) begin
            @(negedge clk);
            n++;
        end
        check(req, n, exp);
    endtask

    task automatic restart(input logic [11:0] v, input int exp_mod, input string req);
        int n;
        @(negedge clk);
        prog_val = v;
        pll_restart = 1'b1;
        @(negedge clk);
        pll_restart = 1'b0;
        to_pulse(n);
        check({req, " R4 first"}, n, exp_mod - 1);
        period({req, " R1 period"}, exp_mod);
    endtask

    task automatic t_reset();
        int n;
        repeat (3) @(negedge clk);
        check("R6 fb low", fb_out, 0);
        check("R6 func low", func_out, 0);
        rst_n = 1'b1;
        to_pulse(n);
        period("R6 default period", 12);
    endtask

    task automatic t_load();
        restart(12'd100, 108, "R1");
    endtask

    task automatic t_buffer();
        prog_val = 12'd20;
        period("R3 no strobe", 108);
        period("R3 no strobe again", 108);
    endtask

    task automatic t_clamp();
        restart(12'd0, 12, "R2 zero");
        restart(12'd3, 12, "R2 three");
        restart(12'd4, 12, "R2 four");
        restart(12'd5, 13, "R2 five");
        restart(12'd4095, 4103, "R2 max");
    endtask

    task automatic t_hsync();
        int hits;
        func_sel = 1'b1;
        @(negedge clk);
        hsync_in = 1'b1;
        @(negedge clk);
        check("R7 after one edge", func_out, 0);
        @(negedge clk);
        check("R7 pulse", func_out, 1);
        @(negedge clk);
        check("R7 one cycle", func_out, 0);
        hits = 0;
        for (int i = 0; i < 30; i++) begin
            @(negedge clk);
            if (func_out) hits++;
        end
        check("R7 held level", hits, 0);
        check("R8 divider hidden", hits, 0);
        hsync_in = 1'b0;
        repeat (3) @(negedge clk);
        func_sel = 1'b0;
    endtask

    task automatic t_func_div();
        int mism;
        mism = 0;
        restart(12'd10, 18, "R8 setup");
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (func_out != fb_out) mism++;
        end
        check("R8 func follows divider", mism, 0);
    endtask

    task automatic t_ext();
        fbk_sel = 1'b1;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            ext_fb = k[0];
            ext_fb_inv = k[1];
            #1;
            check("R9 external", fb_out, k[0] ^ k[1]);
        end
        ext_fb = 1'b0;
        ext_fb_inv = 1'b0;
        fbk_sel = 1'b0;
    endtask

    initial begin
        t_reset();
        t_load();
        t_buffer();
        t_clamp();
        t_hsync();
        t_func_div();
        t_ext();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule